// File: doc/BRIEF.md
# FIFO Level Readback Swap Register

This block is one register slice of a UART channel. It owns a single readable byte location that normally acts as a general-purpose scratch byte. It can also be switched so that the same location reports how full the receive or transmit FIFO is. Software does not need a second address for the fill levels, and code that ignores the feature still sees a plain scratch byte.

The source is chosen by two controls. The first is a swap-enable bit that lives in a neighbouring feature control register and arrives here as an input. The second is a two-bit level-select field that this block keeps. Software writes the field through a separate, write-only mode register strobe.

In the alternating setting, a small state machine decides which level the next read returns. It has two states:
- `ALT_NEXT_RX`: the next read returns the receive level.
- `ALT_NEXT_TX`: the next read returns the transmit level.

The machine has three transitions:
- Reset enters `ALT_NEXT_RX`.
- Any write of the mode field returns it to `ALT_NEXT_RX`.
- A completed read while alternating is active moves it to the other state.

Top module: `fifo_level_swap_reg`

## Requirements
- R1: After reset, the scratch byte is 0x00, the level-select field is 00 and the alternation machine is in `ALT_NEXT_RX`. With swap disabled, `rd_data` is then 0x00; with swap enabled, it is the receive level.
- R2: While `swap_en` is 0, `rd_data` returns the stored scratch byte, whatever value the level-select field holds.
- R3: While `swap_en` is 1 and bit 0 of the level-select field is 0 (field 00 or 10), `rd_data` returns the receive level.
- R4: While `swap_en` is 1 and the level-select field is 01, `rd_data` returns the transmit level.
- R5: While `swap_en` is 1 and the level-select field is 11, the first read after the field is written returns the receive level. Reads after that alternate: transmit, receive, transmit, and so on.
- R6: The alternation advances only on a clock edge where `lvl_rd` is high, `swap_en` is 1 and the field is 11. Idle cycles do not move it. Reads made while swap is disabled, or while another field value is selected, do not move it either.
- R7: A write to the level-select field returns the alternation to the receive level, including a rewrite of 11 in the middle of a sequence. If a field write and a read fall in the same cycle, the write wins.
- R8: A scratch write (`scratch_wr`) stores `wr_data` even while swap is enabled. The stored byte reappears at `rd_data` once swap is disabled.
- R9: The level-select field is taken from `wr_data[1:0]` on `mode_wr`. It has no read path, and a field write leaves the scratch byte unchanged.
- R10: Level counts are 7-bit values from 0 to 64, zero-extended onto the 8-bit read bus. A level of 64 reads as 0x40, and bit 7 of any level readback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scratch_wr | input | 1 | Write strobe for the scratch byte location |
| mode_wr | input | 1 | Write strobe for the write-only level-select field |
| lvl_rd | input | 1 | Read strobe for the shared location; a read completes at the clock edge |
| wr_data | input | 8 | Bus write data |
| swap_en | input | 1 | Swap-enable bit from the feature control register |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| tx_level | input | 7 | Transmit FIFO fill level, 0 to 64 |
| rd_data | output | 8 | Read data of the shared location, combinational from current state |

## Verification
The assertions assume the following about the inputs:
- Each strobe is synchronous to `clk` and lasts one cycle per access.
- The level inputs never exceed 64.
- `rd_data` is read while `lvl_rd` is high, before the edge that completes the read.

The bench keeps to this by driving every input on the falling edge and holding each strobe for exactly one cycle. It generates levels modulo 65 and samples `rd_data` just after driving the strobe. It also covers coincident mode writes and idle gaps, so that the advance rule and the restart rule are each exercised on their own.

// File: rtl/fifo_level_swap_pkg.sv
package fifo_level_swap_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_TX_ONLY = 2'b01;
    localparam logic [MODE_W-1:0] MODE_ALT     = 2'b11;

    typedef enum logic [1:0] {
        SRC_SCRATCH = 2'd0,
        SRC_RX      = 2'd1,
        SRC_TX      = 2'd2
    } rd_src_t;

    typedef enum logic {
        ALT_NEXT_RX = 1'b0,
        ALT_NEXT_TX = 1'b1
    } alt_state_t;

endpackage

// File: rtl/lvl_scratch_store.sv
module lvl_scratch_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= din;
        end
    end

endmodule

// File: rtl/lvl_mode_seq.sv
module lvl_mode_seq
    import fifo_level_swap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              swap_en,
    input  logic              rd_stb,
    output logic [MODE_W-1:0] mode_q,
    output alt_state_t        state_q,
    output rd_src_t           src
);

    alt_state_t state_d;
    logic       advance;

    // Level-select field: written only, never read back.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_din;
        end
    end

    assign advance = rd_stb && swap_en && (mode_q == MODE_ALT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ALT_NEXT_RX;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = ALT_NEXT_RX;
        end else if (advance) begin
            unique case (state_q)
                ALT_NEXT_RX: state_d = ALT_NEXT_TX;
                ALT_NEXT_TX: state_d = ALT_NEXT_RX;
            endcase
        end
    end

    // Outputs: read source
    always_comb begin
        if (!swap_en) begin
            src = SRC_SCRATCH;
        end else if (!mode_q[0]) begin
            src = SRC_RX;
        end else if (mode_q == MODE_TX_ONLY) begin
            src = SRC_TX;
        end else begin
            unique case (state_q)
                ALT_NEXT_RX: src = SRC_RX;
                ALT_NEXT_TX: src = SRC_TX;
            endcase
        end
    end

endmodule

// File: rtl/lvl_read_mux.sv
module lvl_read_mux
    import fifo_level_swap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 7
) (
    input  rd_src_t           src,
    input  logic [DATA_W-1:0] scratch,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - LVL_W;

    logic [DATA_W-1:0] rx_ext;
    logic [DATA_W-1:0] tx_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rx_ext = {{PAD_W{1'b0}}, rx_level};
            assign tx_ext = {{PAD_W{1'b0}}, tx_level};
        end else begin : g_nopad
            assign rx_ext = rx_level[DATA_W-1:0];
            assign tx_ext = tx_level[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src)
            SRC_SCRATCH: rd_data = scratch;
            SRC_RX:      rd_data = rx_ext;
            SRC_TX:      rd_data = tx_ext;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fifo_level_swap_reg.sv
module fifo_level_swap_reg
    import fifo_level_swap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scratch_wr,
    input  logic              mode_wr,
    input  logic              lvl_rd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              swap_en,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] scratch_q;
    logic [MODE_W-1:0] mode_q;
    alt_state_t        alt_state;
    rd_src_t           src;

    lvl_scratch_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (scratch_wr),
        .din   (wr_data),
        .q     (scratch_q)
    );

    lvl_mode_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_din (wr_data[MODE_W-1:0]),
        .swap_en  (swap_en),
        .rd_stb   (lvl_rd),
        .mode_q   (mode_q),
        .state_q  (alt_state),
        .src      (src)
    );

    lvl_read_mux #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_mux (
        .src      (src),
        .scratch  (scratch_q),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/fifo_level_swap_chk.sv
module fifo_level_swap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scratch_wr,
    input logic       mode_wr,
    input logic       lvl_rd,
    input logic [7:0] wr_data,
    input logic       swap_en,
    input logic [6:0] rx_level,
    input logic [6:0] tx_level,
    input logic [7:0] rd_data,
    input logic [1:0] mode_q,
    input logic       alt_tx
);

    logic alt_active;
    assign alt_active = swap_en && (mode_q == 2'b11);

    // R2 / R8: a scratch write is visible at the next cycle whenever swap is off
    p_scratch_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scratch_wr |=> (swap_en || rd_data == $past(wr_data)));

    // R3
    p_rx_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && !mode_q[0]) |-> (rd_data == {1'b0, rx_level}));

    // R4
    p_tx_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_en && mode_q == 2'b01) |-> (rd_data == {1'b0, tx_level}));

    // R5: alternating readback follows the sequencer state
    p_alt_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alt_active |-> (rd_data == (alt_tx ? {1'b0, tx_level} : {1'b0, rx_level})));

    // R6
    p_toggle_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_rd && alt_active && !mode_wr) |=> (alt_tx != $past(alt_tx)));

    p_hold_otherwise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(lvl_rd && alt_active) && !mode_wr) |=> $stable(alt_tx));

    // R7
    p_restart_on_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !alt_tx);

    // R10
    p_zero_extend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |-> !rd_data[7]);

endmodule

bind fifo_level_swap_reg fifo_level_swap_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scratch_wr (scratch_wr),
    .mode_wr    (mode_wr),
    .lvl_rd     (lvl_rd),
    .wr_data    (wr_data),
    .swap_en    (swap_en),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rd_data    (rd_data),
    .mode_q     (mode_q),
    .alt_tx     (alt_state == fifo_level_swap_pkg::ALT_NEXT_TX)
);

// File: tb/fifo_level_swap_reg_bench.sv
`timescale 1ns/1ps
module fifo_level_swap_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scratch_wr = 1'b0;
    logic       mode_wr = 1'b0;
    logic       lvl_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       swap_en = 1'b0;
    logic [6:0] rx_level = 7'd5;
    logic [6:0] tx_level = 7'd9;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [7:0] m_scratch;
    logic [1:0] m_mode;
    bit         m_alt_tx;

    always #4 clk = ~clk;

    fifo_level_swap_reg u_fifo_level_swap_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .scratch_wr (scratch_wr),
        .mode_wr    (mode_wr),
        .lvl_rd     (lvl_rd),
        .wr_data    (wr_data),
        .swap_en    (swap_en),
        .rx_level   (rx_level),
        .tx_level   (tx_level),
        .rd_data    (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIFO-level bench FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic write_scratch(input logic [7:0] v);
        @(negedge clk);
        scratch_wr = 1'b1;
        wr_data = v;
        @(negedge clk);
        scratch_wr = 1'b0;
        m_scratch = v;
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        mode_wr = 1'b1;
        wr_data = v;
        @(negedge clk);
        mode_wr = 1'b0;
        m_mode = v[1:0];
        m_alt_tx = 1'b0;
    endtask

    task automatic set_swap(input logic s);
        @(negedge clk);
        swap_en = s;
    endtask

    function automatic logic [7:0] model_value();
        if (!swap_en) return m_scratch;
        if (!m_mode[0]) return {1'b0, rx_level};
        if (m_mode == 2'b01) return {1'b0, tx_level};
        return m_alt_tx ? {1'b0, tx_level} : {1'b0, rx_level};
    endfunction

    // one read: strobe at negedge, sample, edge completes it
    task automatic read_check(input string req);
        @(negedge clk);
        lvl_rd = 1'b1;
        #1;
        check(req, rd_data, model_value());
        @(negedge clk);
        lvl_rd = 1'b0;
        if (swap_en && m_mode == 2'b11) m_alt_tx = !m_alt_tx;
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FIFO-level bench FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_scratch = 8'h00;
        m_mode = 2'b00;
        m_alt_tx = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 scratch reset", rd_data, 8'h00);
        swap_en = 1'b1;
        #1;
        check("R1 field reset selects rx", rd_data, {1'b0, rx_level});
        swap_en = 1'b0;

        // sweep over swap and every level-select value
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                set_swap(s[0]);
                write_scratch(8'h30 + 8'(m * 17 + s * 5));
                write_mode({6'b101010, m[1:0]});
                for (int i = 0; i < 6; i++) begin
                    @(negedge clk);
                    rx_level = 7'((i * 13 + m * 7 + s) % 65);
                    tx_level = 7'(64 - ((i * 29 + m) % 65));
                    if (s == 0)      read_check("R2 swap off");
                    else if (m == 0 || m == 2) read_check("R3 rx select");
                    else if (m == 1) read_check("R4 tx select");
                    else             read_check("R5 alternate");
                end
            end
        end

        // R10 boundaries
        set_swap(1'b1);
        write_mode(8'h00);
        rx_level = 7'd64;
        read_check("R10 rx 64");
        rx_level = 7'd0;
        read_check("R10 rx 0");
        write_mode(8'h01);
        tx_level = 7'd64;
        read_check("R10 tx 64");

        // R5 explicit order
        rx_level = 7'd11;
        tx_level = 7'd22;
        write_mode(8'h03);
        @(negedge clk); lvl_rd = 1'b1; #1; check("R5 first read rx", rd_data, 8'd11);
        @(negedge clk); #1; check("R5 second read tx", rd_data, 8'd22);
        @(negedge clk); #1; check("R5 third read rx", rd_data, 8'd11);
        @(negedge clk); lvl_rd = 1'b0; m_alt_tx = 1'b1;

        // R6: idle cycles and reads outside alternating do not advance
        repeat (5) @(negedge clk);
        #1; check("R6 idle hold tx", rd_data, 8'd22);
        read_check("R6 tx after idle");
        set_swap(1'b0);
        read_check("R6 swap-off read");
        read_check("R6 swap-off read");
        set_swap(1'b1);
        read_check("R6 resumes rx");

        // R7: rewrite mid-sequence restarts on rx
        read_check("R7 pre tx");
        write_mode(8'h03);
        read_check("R7 restart rx");
        read_check("R7 then tx");
        // same-cycle mode write and read: write wins
        @(negedge clk);
        lvl_rd = 1'b1; mode_wr = 1'b1; wr_data = 8'h03;
        @(negedge clk);
        lvl_rd = 1'b0; mode_wr = 1'b0;
        m_alt_tx = 1'b0;
        read_check("R7 coincident write wins rx");

        // R8: scratch write while swapped, then visible when swap off
        write_scratch(8'h5A);
        read_check("R8 still level while swapped");
        set_swap(1'b0);
        read_check("R8 scratch returns");
        check("R8 stored value", rd_data, 8'h5A);

        // R9: field write leaves scratch alone, no readback of field
        write_mode(8'hC3);
        read_check("R9 scratch unchanged by field write");
        check("R9 value", rd_data, 8'h5A);
        set_swap(1'b1);
        read_check("R9 field value 11 took effect rx");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule